// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is one arithmetic slice for filter and modulation datapaths. Two wide operands first meet in a pre-adder, which adds or subtracts them. Alternatively, one of them bypasses the pre-adder. The chosen value is multiplied by a narrower signed coefficient. The sign-extended product then enters a wide post-adder. That adder combines it, by addition or subtraction, with one selectable operand and an optional carry bit. The selectable operand is zero, an external operand, a cascade value from a neighbouring slice, or the slice's own registered result. One slice can therefore compute a symmetric FIR tap, a chained sum of products, or a running accumulation.

Each of the four pipeline stages can be kept or removed by a static parameter. The four stages are the input registers, the pre-adder result register, the product register and the result register. A 7-bit mode word is captured with the operands. It travels down the pipeline with them, so every control field acts on the data it was issued with. The external operand and the carry bit are also delayed to match. A synchronous reset clears every register. A clock enable freezes the whole pipeline without losing its contents.

The result drives a cascade output for the next slice. The coefficient, as captured by the input stage, drives a second cascade output.

Top module: `pams_slice`

## Requirements
- R1: With mode bit 1 set, the multiplier operand is D + A when mode bit 0 is 0 and D − A when mode bit 0 is 1. The result wraps modulo 2^A_W. With mode bit 1 clear, A goes to the multiplier unchanged and D is ignored.
- R2: The product of the multiplier operand and B is signed (two's complement, A_W × B_W bits). It is sign-extended to P_W bits before the post-adder.
- R3: Mode bits [3:2] select the post-adder operand Z: 00 gives zero, 01 gives C, 10 gives the cascade input, and 11 gives the slice's own registered result. The 11 code gives zero when the result register is bypassed.
- R4: Mode bit 4 includes the product in the post-adder, and mode bit 6 includes the carry input. Let X be the sum of those included terms. The result is Z + X when mode bit 5 is 0 and Z − X when it is 1, in both cases wrapping modulo 2^P_W.
- R5: Mode 0x1E feeds back the result and adds the pre-added product, so the slice accumulates once per enabled clock. Mode 0x0C holds the result unchanged.
- R6: With all stages present, a result appears on P exactly 4 clocks after its operands, mode and carry are presented. C is delayed to match, and the cascade input is used as it stands at the post-adder.
- R7: With every stage bypassed, P is a purely combinational function of the present inputs.
- R8: While the clock enable is low, no register changes and the operand, mode, C and carry inputs have no effect. Operation resumes without losing data.
- R9: A synchronous reset, which takes priority over the enable, clears every register, so P and both cascade outputs read zero.
- R10: The result cascade output always equals P. The coefficient cascade output equals B as held by the input stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every pipeline register |
| mode_in | input | 7 | Mode control word |
| a_in | input | A_W | Operand A |
| d_in | input | A_W | Operand D |
| b_in | input | B_W | Coefficient B |
| c_in | input | P_W | External post-adder operand |
| cin_in | input | 1 | Carry input |
| pcas_in | input | P_W | Result cascade from the previous slice |
| p_out | output | P_W | Result |
| pcas_out | output | P_W | Result cascade to the next slice |
| bcas_out | output | B_W | Coefficient cascade to the next slice |

## Verification
The bench builds the slice with A_W=5, B_W=4 and P_W=12. At these widths every one of the 1024 D/A pairs passes through the pre-adder, and every A value meets every B value in the multiplier. Wrap-around at both adders also occurs constantly rather than rarely. One instance keeps all four stages, which exercises latency, stall, reset and accumulation. A second instance, fed the same inputs, bypasses every stage so the combinational path is checked against the same arithmetic model.

// File: rtl/pams_pkg.sv
package pams_pkg;
  localparam int MODE_W = 7;

  // mode word bit positions
  localparam int MB_PRE_SUB  = 0;
  localparam int MB_PRE_USED = 1;
  localparam int MB_ZSEL_LO  = 2;
  localparam int MB_MUL_EN   = 4;
  localparam int MB_POST_SUB = 5;
  localparam int MB_CIN_EN   = 6;

  // post-stage control bundle: {mode[6:2], cin}
  localparam int CTL_W = MODE_W - 1;

  typedef enum logic [1:0] {
    Z_ZERO = 2'b00,
    Z_EXT  = 2'b01,
    Z_CASC = 2'b10,
    Z_FB   = 2'b11
  } zsel_e;
endpackage

// File: rtl/pams_stage.sv
module pams_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/pams_preadd.sv
module pams_preadd #(
  parameter int AW = 25
) (
  input  logic          use_d,
  input  logic          sub,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] op
);
  logic [AW-1:0] comb_sum;

  always_comb begin
    comb_sum = sub ? (d - a) : (d + a);
    op       = use_d ? comb_sum : a;
  end
endmodule

// File: rtl/pams_mult.sv
module pams_mult #(
  parameter int AW = 25,
  parameter int BW = 18,
  parameter int PW = 48
) (
  input  logic [AW-1:0] op,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] m_ext
);
  localparam int MW = AW + BW;

  logic signed [MW-1:0] prod;

  always_comb begin
    prod  = MW'($signed(op)) * MW'($signed(b));
    m_ext = {{(PW-MW){prod[MW-1]}}, prod};
  end
endmodule

// File: rtl/pams_postadd.sv
module pams_postadd
  import pams_pkg::*;
#(
  parameter int PW = 48
) (
  input  logic [1:0]    zsel,
  input  logic          mul_en,
  input  logic          post_sub,
  input  logic          cin_en,
  input  logic          cin,
  input  logic [PW-1:0] c,
  input  logic [PW-1:0] casc,
  input  logic [PW-1:0] fb,
  input  logic [PW-1:0] m,
  output logic [PW-1:0] sum
);
  logic [PW-1:0] z;
  logic [PW-1:0] addend;

  always_comb begin
    unique case (zsel_e'(zsel))
      Z_ZERO:  z = '0;
      Z_EXT:   z = c;
      Z_CASC:  z = casc;
      default: z = fb;
    endcase
    addend = (mul_en ? m : '0) + {{(PW-1){1'b0}}, cin_en & cin};
    sum    = post_sub ? (z - addend) : (z + addend);
  end
endmodule

// File: rtl/pams_slice.sv
module pams_slice
  import pams_pkg::*;
#(
  parameter int A_W    = 25,
  parameter int B_W    = 18,
  parameter int P_W    = 48,
  parameter bit IN_REG = 1'b1,
  parameter bit AD_REG = 1'b1,
  parameter bit M_REG  = 1'b1,
  parameter bit P_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [A_W-1:0]    a_in,
  input  logic [A_W-1:0]    d_in,
  input  logic [B_W-1:0]    b_in,
  input  logic [P_W-1:0]    c_in,
  input  logic              cin_in,
  input  logic [P_W-1:0]    pcas_in,
  output logic [P_W-1:0]    p_out,
  output logic [P_W-1:0]    pcas_out,
  output logic [B_W-1:0]    bcas_out
);
  localparam int M_W    = A_W + B_W;
  localparam int CTL1_W = MODE_W + 1;
  localparam int EXT_W  = P_W - M_W + 1;

  // stage 1: input registers
  logic [A_W-1:0]    a1, d1;
  logic [B_W-1:0]    b1;
  logic [P_W-1:0]    c1;
  logic [CTL1_W-1:0] ctl1;

  pams_stage #(.W(A_W),    .EN(IN_REG)) u_s1_a   (.clk, .rst, .ce, .d(a_in), .q(a1));
  pams_stage #(.W(A_W),    .EN(IN_REG)) u_s1_d   (.clk, .rst, .ce, .d(d_in), .q(d1));
  pams_stage #(.W(B_W),    .EN(IN_REG)) u_s1_b   (.clk, .rst, .ce, .d(b_in), .q(b1));
  pams_stage #(.W(P_W),    .EN(IN_REG)) u_s1_c   (.clk, .rst, .ce, .d(c_in), .q(c1));
  pams_stage #(.W(CTL1_W), .EN(IN_REG)) u_s1_ctl (.clk, .rst, .ce,
                                                   .d({mode_in, cin_in}), .q(ctl1));

  // pre-adder (ctl1 = {mode, cin})
  logic [A_W-1:0] ad_op;

  pams_preadd #(.AW(A_W)) u_preadd (
    .use_d (ctl1[MB_PRE_USED+1]),
    .sub   (ctl1[MB_PRE_SUB+1]),
    .a     (a1),
    .d     (d1),
    .op    (ad_op)
  );

  // stage 2: pre-adder result; pre-adder bits dropped from the control bundle
  logic [A_W-1:0]   ad2;
  logic [B_W-1:0]   b2;
  logic [P_W-1:0]   c2;
  logic [CTL_W-1:0] ctl2;

  pams_stage #(.W(A_W),   .EN(AD_REG)) u_s2_ad  (.clk, .rst, .ce, .d(ad_op), .q(ad2));
  pams_stage #(.W(B_W),   .EN(AD_REG)) u_s2_b   (.clk, .rst, .ce, .d(b1),    .q(b2));
  pams_stage #(.W(P_W),   .EN(AD_REG)) u_s2_c   (.clk, .rst, .ce, .d(c1),    .q(c2));
  pams_stage #(.W(CTL_W), .EN(AD_REG)) u_s2_ctl (.clk, .rst, .ce,
                                                  .d({ctl1[CTL1_W-1:MB_ZSEL_LO+1], ctl1[0]}),
                                                  .q(ctl2));

  // multiplier
  logic [P_W-1:0] m_ext;

  pams_mult #(.AW(A_W), .BW(B_W), .PW(P_W)) u_mult (
    .op    (ad2),
    .b     (b2),
    .m_ext (m_ext)
  );

  // stage 3: product register; ctl3 = {cin_en, post_sub, mul_en, zsel[1:0], cin}
  logic [P_W-1:0]   m3;
  logic [P_W-1:0]   c3;
  logic [CTL_W-1:0] ctl3;

  pams_stage #(.W(P_W),   .EN(M_REG)) u_s3_m   (.clk, .rst, .ce, .d(m_ext), .q(m3));
  pams_stage #(.W(P_W),   .EN(M_REG)) u_s3_c   (.clk, .rst, .ce, .d(c2),    .q(c3));
  pams_stage #(.W(CTL_W), .EN(M_REG)) u_s3_ctl (.clk, .rst, .ce, .d(ctl2),  .q(ctl3));

  // post-adder
  logic [P_W-1:0] fb;
  logic [P_W-1:0] p_sum;

  pams_postadd #(.PW(P_W)) u_postadd (
    .zsel     (ctl3[2:1]),
    .mul_en   (ctl3[3]),
    .post_sub (ctl3[4]),
    .cin_en   (ctl3[5]),
    .cin      (ctl3[0]),
    .c        (c3),
    .casc     (pcas_in),
    .fb       (fb),
    .m        (m3),
    .sum      (p_sum)
  );

  // stage 4: result register
  pams_stage #(.W(P_W), .EN(P_REG)) u_s4_p (.clk, .rst, .ce, .d(p_sum), .q(p_out));

  generate
    if (P_REG) begin : g_fb
      assign fb = p_out;
    end else begin : g_nofb
      assign fb = '0;
    end
  endgenerate

  assign pcas_out = p_out;
  assign bcas_out = b1;

  // R2: upper product bits all copy the product sign
  a_r2_sign_ext: assert property (@(posedge clk) disable iff (rst)
    ($countones(m_ext[P_W-1:M_W-1]) == 0) || ($countones(m_ext[P_W-1:M_W-1]) == EXT_W));

  generate
    if (P_REG) begin : g_p_chk
      // R8: a stalled clock leaves the result untouched
      a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(p_out));
      // R9: reset clears the result whatever the enable does
      a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (p_out == '0));
      // R5: feedback with nothing added keeps the result
      a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (ce && ctl3[2:1] == 2'b11 && !ctl3[3] && !ctl3[5]) |=> $stable(p_out));
    end
    if (IN_REG) begin : g_b_chk
      // R10: coefficient cascade follows the captured coefficient
      a_r10_bcas_follow: assert property (@(posedge clk) disable iff (rst)
        ce |=> (bcas_out == $past(b_in)));
      // R8: coefficient cascade frozen while stalled
      a_r8_bcas_stall: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(bcas_out));
    end
  endgenerate
endmodule

// File: tb/pams_slice_tb_top.sv
module pams_slice_tb_top;
  localparam int AW = 5;
  localparam int BW = 4;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b0;
  logic [6:0]    mode_in = '0;
  logic [AW-1:0] a_in = '0, d_in = '0;
  logic [BW-1:0] b_in = '0;
  logic [PW-1:0] c_in = '0;
  logic          cin_in = 1'b0;
  logic [PW-1:0] pcas_in = 12'h5a3;
  logic [PW-1:0] p_out, pcas_out, p_comb, pcas_comb;
  logic [BW-1:0] bcas_out, bcas_comb;

  always #2 clk = ~clk;

  pams_slice #(.A_W(AW), .B_W(BW), .P_W(PW)) dut_i (
    .clk, .rst, .ce, .mode_in, .a_in, .d_in, .b_in, .c_in, .cin_in, .pcas_in,
    .p_out, .pcas_out, .bcas_out
  );

  pams_slice #(.A_W(AW), .B_W(BW), .P_W(PW),
               .IN_REG(1'b0), .AD_REG(1'b0), .M_REG(1'b0), .P_REG(1'b0)) dut_comb_i (
    .clk, .rst, .ce, .mode_in, .a_in, .d_in, .b_in, .c_in, .cin_in, .pcas_in,
    .p_out(p_comb), .pcas_out(pcas_comb), .bcas_out(bcas_comb)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] last_p = '0;
  logic [BW-1:0] prev_b = '0;

  task automatic chk(input logic [PW-1:0] act, input logic [PW-1:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] model(input logic [AW-1:0] dv, input logic [AW-1:0] av,
                                          input logic [BW-1:0] bv, input logic [PW-1:0] cv,
                                          input logic [6:0] mv, input logic cinv,
                                          input logic [PW-1:0] casc, input logic [PW-1:0] fbv);
    logic [AW-1:0] ad;
    int ads, bs, z, x, r;
    ad  = mv[1] ? (mv[0] ? dv - av : dv + av) : av;
    ads = ad[AW-1] ? int'(ad) - (1 << AW) : int'(ad);
    bs  = bv[BW-1] ? int'(bv) - (1 << BW) : int'(bv);
    case (mv[3:2])
      2'b00:   z = 0;
      2'b01:   z = int'(cv);
      2'b10:   z = int'(casc);
      default: z = int'(fbv);
    endcase
    x = (mv[4] ? ads * bs : 0) + ((mv[6] && cinv) ? 1 : 0);
    r = mv[5] ? z - x : z + x;
    return r[PW-1:0];
  endfunction

  task automatic pop_check();
    if (exp_q.size() == 4) begin
      logic [PW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(p_out, e, t);
      chk(pcas_out, p_out, "R10 pcas");
    end
  endtask

  task automatic vec(input logic [AW-1:0] dv, input logic [AW-1:0] av, input logic [BW-1:0] bv,
                     input logic [PW-1:0] cv, input logic [6:0] mv, input logic cinv,
                     input string tag);
    logic [PW-1:0] e;
    @(negedge clk);
    pop_check();
    chk({{(PW-BW){1'b0}}, bcas_out}, {{(PW-BW){1'b0}}, prev_b}, "R10 bcas");
    rst = 1'b0; ce = 1'b1;
    d_in = dv; a_in = av; b_in = bv; c_in = cv; mode_in = mv; cin_in = cinv;
    e = model(dv, av, bv, cv, mv, cinv, pcas_in, last_p);
    last_p = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    prev_b = bv;
    #1;
    chk(p_comb, model(dv, av, bv, cv, mv, cinv, pcas_in, '0), "R7 comb");
  endtask

  task automatic stall(input int n);
    logic [PW-1:0] hold;
    @(negedge clk);
    pop_check();
    ce = 1'b0;
    d_in = ~d_in; a_in = a_in ^ 5'h15; b_in = ~b_in; c_in = ~c_in;
    mode_in = 7'h16; cin_in = ~cin_in;
    hold = p_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(p_out, hold, "R8 stall p");
      chk({{(PW-BW){1'b0}}, bcas_out}, {{(PW-BW){1'b0}}, prev_b}, "R8 stall b");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b0;
    exp_q.delete(); tag_q.delete();
    @(negedge clk);
    chk(p_out, '0, "R9 p");
    chk(pcas_out, '0, "R9 pcas");
    chk({{(PW-BW){1'b0}}, bcas_out}, '0, "R9 bcas");
    last_p = '0; prev_b = '0;
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back('0);
      tag_q.push_back("R6 fill");
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pop_check();
      ce = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    // R6: single result then zeros; latency checked by queue order
    vec(5'd9, 5'd4, 4'd3, 12'h123, 7'h16, 1'b0, "R6 latency");
    for (int i = 0; i < 4; i++) vec('0, '0, '0, '0, 7'h00, 1'b0, "R6 idle");

    // R1 / R4: all D/A pairs, pre-add and pre-sub with carry
    for (int d = 0; d < 32; d++)
      for (int a = 0; a < 32; a++) begin
        logic [AW-1:0] dv, av;
        dv = AW'(d); av = AW'(a);
        vec(dv, av, BW'(d * 7 + a), PW'(d * 37 + a * 11), av[0] ? 7'h57 : 7'h16,
            av[1], av[0] ? "R4 presub+cin" : "R1 preadd");
      end

    // R2 / R3: A passed through, every A x B, cascade subtract
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 16; b++) begin
        logic [BW-1:0] bv;
        bv = BW'(b);
        vec(AW'(a * 3), AW'(a), bv, PW'(a), bv[1] ? 7'h78 : 7'h38, bv[0],
            bv[1] ? "R3 casc sub cin" : "R2 pass product");
      end

    // R5 / R8: accumulate with a stall in the middle
    do_reset();
    for (int i = 0; i < 10; i++) vec(5'd5, 5'd3, 4'hd, 12'h0, 7'h1E, 1'b0, "R5 acc");
    stall(5);
    for (int i = 0; i < 10; i++) vec(5'd5, 5'd3, 4'hd, 12'h0, 7'h1E, 1'b0, "R8 acc resume");
    for (int i = 0; i < 6; i++) vec(5'd7, 5'd1, 4'h7, 12'hfff, 7'h0C, 1'b1, "R5 hold");
    for (int i = 0; i < 4; i++) vec('0, '0, '0, '0, 7'h40, 1'b1, "R4 carry only");
    drain();

    // R9: reset after nonzero traffic
    do_reset();
    for (int i = 0; i < 6; i++) vec(5'd1, 5'd2, 4'd5, 12'h010, 7'h16, 1'b0, "R6 after reset");
    drain();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule